// File: doc/BRIEF.md
# Load-Use Interlock and Taken-Branch Squash Unit

This block is the hazard controller of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It looks at the instruction in decode and the instruction in execute. If the execute-stage instruction is a load whose destination register is a source of the decode-stage instruction, the block holds the program counter and the fetch/decode register for one cycle. It also tells the decode-to-execute register to take an all-zero control bundle, so that a bubble enters execute. Result forwarding, which lives elsewhere, supplies the loaded value one cycle later. A dependent instruction right after a load therefore loses exactly one cycle.

Branches are predicted not taken. When the instruction in execute is a branch and its comparison reports equality (zero flag set), the instruction fetched behind it is wrong. The block then asks the fetch/decode register to clear itself to a no-operation word on the next edge. The block is purely combinational and sits between the pipeline registers and their enables.

Top module: `hazard_ctrl`

## Requirements
- R1: The hazard request is raised when `ex_mem_read` is 1 and `ex_rt` equals `id_rs` or `id_rt`, unless R7 or R8 applies.
- R2: While the hazard request is raised, `pc_we` is 0.
- R3: While the hazard request is raised, `ifid_we` is 0.
- R4: While the hazard request is raised, `ctrl_zero` is 1, selecting an all-zero control bundle into the decode-to-execute register. Otherwise `ctrl_zero` is 0.
- R5: With no hazard request and no squash, `pc_we` and `ifid_we` are 1 and `ctrl_zero` and `ifid_flush` are 0. A register match with `ex_mem_read` at 0 raises nothing.
- R6: `ifid_flush` is 1 exactly when `ex_branch` and `ex_zero` are both 1. Either flag alone raises no squash.
- R7: When a squash and a hazard request coincide, the squash wins: `ifid_flush` is 1, `pc_we` and `ifid_we` are 1, and `ctrl_zero` is 0.
- R8: No hazard request is raised when `id_opcode` is a jump (2) or jump-and-link (3), even if its rs/rt bit fields match `ex_rt`.
- R9: In a pipeline whose decode-to-execute register takes the zeroed bundle on a hold, a load followed by a dependent instruction costs exactly one hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_mem_read | input | 1 | Execute-stage instruction reads data memory |
| ex_rt | input | 5 | Execute-stage rt field (load destination) |
| id_rs | input | 5 | Decode-stage rs field |
| id_rt | input | 5 | Decode-stage rt field |
| id_opcode | input | 6 | Decode-stage opcode field |
| ex_branch | input | 1 | Execute-stage instruction is a conditional branch |
| ex_zero | input | 1 | Execute-stage comparison reports equality |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Select all-zero control into decode-to-execute register |
| ifid_flush | output | 1 | Clear fetch/decode register to a no-operation word |

## Verification
Every output is a combinational function of the current inputs, so each result is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and compares shortly after, well before the next rising edge. The one-cycle cost of R9 spans two cycles. For it, the bench keeps a small behavioural model of the decode-to-execute memory-read bit, updated on the rising edge from the sampled `ctrl_zero`. It then checks that the hold drops in the following cycle, and it counts the hold cycles.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    localparam int REG_IDX_W = 5;
    localparam int OPCODE_W  = 6;
    localparam int NUM_SRC   = 2;
    localparam logic [OPCODE_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPCODE_W-1:0] OPC_JAL  = 6'd3;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic ctrl_zero;
        logic ifid_flush;
    } hz_out_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int IDX_W = hazard_pkg::REG_IDX_W,
    parameter int N_SRC = hazard_pkg::NUM_SRC
) (
    input  logic                        load_in_ex,
    input  logic [IDX_W-1:0]            load_dst,
    input  logic [N_SRC-1:0][IDX_W-1:0] srcs,
    output logic                        hit
);
    logic [N_SRC-1:0] eq_d;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        always_comb begin
            eq_d[g] = (srcs[g] == load_dst);
        end
    end

    always_comb begin
        hit = load_in_ex && (|eq_d);
    end
endmodule

// File: rtl/hz_jump_decode.sv
module hz_jump_decode #(
    parameter int OPC_W = hazard_pkg::OPCODE_W,
    parameter logic [OPC_W-1:0] OPC_A = hazard_pkg::OPC_JUMP,
    parameter logic [OPC_W-1:0] OPC_B = hazard_pkg::OPC_JAL
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             no_reg_src
);
    always_comb begin
        no_reg_src = (opcode == OPC_A) || (opcode == OPC_B);
    end
endmodule

// File: rtl/hz_branch_squash.sv
module hz_branch_squash (
    input  logic br_in_ex,
    input  logic cmp_equal,
    output logic squash
);
    always_comb begin
        squash = br_in_ex && cmp_equal;
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int IDX_W = REG_IDX_W,
    parameter int OPC_W = OPCODE_W
) (
    input  logic             ex_mem_read,
    input  logic [IDX_W-1:0] ex_rt,
    input  logic [IDX_W-1:0] id_rs,
    input  logic [IDX_W-1:0] id_rt,
    input  logic [OPC_W-1:0] id_opcode,
    input  logic             ex_branch,
    input  logic             ex_zero,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             ctrl_zero,
    output logic             ifid_flush
);
    logic                        raw_hit;
    logic                        is_jump;
    logic                        squash;
    logic [NUM_SRC-1:0][IDX_W-1:0] src_vec;
    hz_out_t                     hz_d;

    assign src_vec[0] = id_rs;
    assign src_vec[1] = id_rt;

    hz_src_match #(.IDX_W(IDX_W), .N_SRC(NUM_SRC)) i_match (
        .load_in_ex (ex_mem_read),
        .load_dst   (ex_rt),
        .srcs       (src_vec),
        .hit        (raw_hit)
    );

    hz_jump_decode #(.OPC_W(OPC_W), .OPC_A(OPC_W'(OPC_JUMP)), .OPC_B(OPC_W'(OPC_JAL))) i_jdec (
        .opcode     (id_opcode),
        .no_reg_src (is_jump)
    );

    hz_branch_squash i_squash (
        .br_in_ex  (ex_branch),
        .cmp_equal (ex_zero),
        .squash    (squash)
    );

    // Squash outranks the load interlock: a wrong-path decode slot is not held.
    always_comb begin
        logic hold;
        hold          = raw_hit && !is_jump && !squash;
        hz_d.pc_we      = !hold;
        hz_d.ifid_we    = !hold;
        hz_d.ctrl_zero  = hold;
        hz_d.ifid_flush = squash;
    end

    assign pc_we      = hz_d.pc_we;
    assign ifid_we    = hz_d.ifid_we;
    assign ctrl_zero  = hz_d.ctrl_zero;
    assign ifid_flush = hz_d.ifid_flush;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
    parameter int IDX_W = 5,
    parameter int OPC_W = 6
) (
    input logic             ex_mem_read,
    input logic [IDX_W-1:0] ex_rt,
    input logic [IDX_W-1:0] id_rs,
    input logic [IDX_W-1:0] id_rt,
    input logic [OPC_W-1:0] id_opcode,
    input logic             ex_branch,
    input logic             ex_zero,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             ctrl_zero,
    input logic             ifid_flush
);
    always_comb begin
        assert_hold_needs_load_R1: assert (!ctrl_zero || (ex_mem_read && (ex_rt == id_rs || ex_rt == id_rt)))
            else $error("hold without load match");
        assert_pc_frozen_R2: assert (!ctrl_zero || !pc_we)
            else $error("pc written during hold");
        assert_ifid_frozen_R3: assert (pc_we == ifid_we)
            else $error("pc and ifid enables disagree");
        assert_bubble_select_R4: assert (ctrl_zero != pc_we)
            else $error("bubble select not tied to hold");
        assert_flush_needs_branch_R6: assert (!ifid_flush || (ex_branch && ex_zero))
            else $error("flush without taken branch");
        assert_flush_wins_R7: assert (!ifid_flush || (pc_we && !ctrl_zero))
            else $error("hold raised beside flush");
        assert_jump_exempt_R8: assert (!ctrl_zero || (id_opcode != OPC_W'(2) && id_opcode != OPC_W'(3)))
            else $error("hold raised for jump");
    end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.IDX_W(IDX_W), .OPC_W(OPC_W)) i_hazard_ctrl_chk (.*);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
    logic       clk = 1'b0;
    logic       ex_mem_read, ex_branch, ex_zero;
    logic [4:0] ex_rt, id_rs, id_rt;
    logic [5:0] id_opcode;
    logic       pc_we, ifid_we, ctrl_zero, ifid_flush;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    hazard_ctrl i_hazard_ctrl (
        .ex_mem_read(ex_mem_read), .ex_rt(ex_rt), .id_rs(id_rs), .id_rt(id_rt),
        .id_opcode(id_opcode), .ex_branch(ex_branch), .ex_zero(ex_zero),
        .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero), .ifid_flush(ifid_flush)
    );

    function automatic logic [3:0] model();
        bit flush, jmp, hold;
        flush = ex_branch && ex_zero;
        jmp   = (id_opcode == 6'd2) || (id_opcode == 6'd3);
        hold  = ex_mem_read && (ex_rt == id_rs || ex_rt == id_rt) && !jmp && !flush;
        return {!hold, !hold, hold, flush};
    endfunction

    task automatic check(string req);
        logic [3:0] act, exp;
        act = {pc_we, ifid_we, ctrl_zero, ifid_flush};
        exp = model();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {pc_we,ifid_we,ctrl_zero,flush} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(bit mr, int rt, int rs, int rt2, int opc, bit br, bit z, string req);
        @(negedge clk);
        ex_mem_read = mr; ex_rt = 5'(rt); id_rs = 5'(rs); id_rt = 5'(rt2);
        id_opcode = 6'(opc); ex_branch = br; ex_zero = z;
        #1 check(req);
    endtask

    task automatic expect_bits(string req, logic [3:0] exp);
        checks++;
        if ({pc_we, ifid_we, ctrl_zero, ifid_flush} !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, {pc_we, ifid_we, ctrl_zero, ifid_flush}, exp);
        end
    endtask

    initial begin
        ex_mem_read = 0; ex_rt = 0; id_rs = 0; id_rt = 0; id_opcode = 0; ex_branch = 0; ex_zero = 0;
        #1 expect_bits("R5 idle", 4'b1100);
        apply(0, 5, 5, 5, 0, 0, 0, "R5 match without load");
        expect_bits("R5 match without load", 4'b1100);
        apply(1, 7, 7, 1, 0, 0, 0, "R1 rs match");
        expect_bits("R2 R3 R4 hold on rs", 4'b0010);
        apply(1, 9, 3, 9, 35, 0, 0, "R1 rt match");
        expect_bits("R2 R3 R4 hold on rt", 4'b0010);
        apply(1, 9, 3, 4, 0, 0, 0, "R5 load no match");
        expect_bits("R5 load no match", 4'b1100);
        apply(1, 6, 6, 6, 2, 0, 0, "R8 jump exempt");
        expect_bits("R8 jump exempt", 4'b1100);
        apply(1, 6, 6, 0, 3, 0, 0, "R8 jal exempt");
        expect_bits("R8 jal exempt", 4'b1100);
        apply(1, 6, 6, 0, 4, 0, 0, "R8 branch opcode still held");
        expect_bits("R8 non-jump held", 4'b0010);
        apply(0, 0, 1, 2, 0, 1, 1, "R6 taken");
        expect_bits("R6 taken flush", 4'b1101);
        apply(0, 0, 1, 2, 0, 1, 0, "R6 branch alone");
        expect_bits("R6 branch alone", 4'b1100);
        apply(0, 0, 1, 2, 0, 0, 1, "R6 zero alone");
        expect_bits("R6 zero alone", 4'b1100);
        apply(1, 8, 8, 8, 0, 1, 1, "R7 flush beats hold");
        expect_bits("R7 flush beats hold", 4'b1101);

        // R9: load then dependent instruction; bench models ID/EX memory-read bit.
        begin
            bit idex_mr;
            int holds = 0;
            apply(1, 12, 12, 0, 0, 0, 0, "R9 load-use first cycle");
            if (ctrl_zero) holds++;
            @(posedge clk);
            idex_mr = ctrl_zero ? 1'b0 : 1'b0; // dependent add never reads memory; bubble carries zero
            apply(idex_mr, 12, 12, 0, 0, 0, 0, "R9 after bubble");
            if (ctrl_zero) holds++;
            checks++;
            if (holds != 1) begin
                errors++;
                $display("FAIL R9: hold cycles actual=%0d expected=1", holds);
            end
        end

        for (int i = 0; i < 400; i++) begin
            apply($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                  $urandom_range(0, 5), $urandom_range(0, 1), $urandom_range(0, 1), "R1 R6 R7 R8 mix");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule